// File: doc/BRIEF.md
# Phase-Slotted Cluster Request Port

This block connects a cluster of `NUM_PHASES` processors to one shared input of an overlapped circuit-switched network. A free-running phase counter gives each processor one slot every `NUM_PHASES` cycles. A processor can place a request on the network only in its own slot. The block registers the request and sends it forward with its destination cluster, its address and write data, and a tag holding the phase number of the sender.

The network gives no busy or blocking feedback. A request that is blocked inside the fabric simply vanishes. The only proof of delivery is the sender's phase tag coming back on the backward port. That echo is the acknowledgment for both writes and reads, and for a read it also carries the data. Each phase keeps its request pending and counts its age. If no echo arrives within one memory cycle (`NUM_PHASES` network cycles), the stored request is sent again in the next slot of that phase. When an echo does arrive, its phase tag selects which processor receives the completion pulse.

Top module: `cluster_req_if`

## Requirements
- R1: While `rst_ni` is low, `phase_o` is 0, and `fwd_valid_o` and `cmpl_o` are all zero.
- R2: After reset, `phase_o` steps by one every clock, wrapping from `NUM_PHASES-1` to 0.
- R3: `req_ready_o[j]` is high only while `phase_o == j` and phase `j` has no live pending request. A request on `req_valid_i[j]` is taken only at a rising edge where `req_ready_o[j]` is high.
- R4: In the cycle after a request from processor `j` is taken, `fwd_valid_o` is 1, `fwd_phase_o` equals `j`, and `fwd_write_o`, `fwd_dest_o`, `fwd_addr_o` and `fwd_wdata_o` carry the values taken. When no request is taken and none is re-sent, `fwd_valid_o` is 0.
- R5: An echo (`bwd_valid_i` = 1 with `bwd_phase_i = j`) while phase `j` is pending clears the pending request. In the next cycle `cmpl_o` equals one-hot bit `j` and `cmpl_rdata_o` equals the sampled `bwd_rdata_i`. Otherwise `cmpl_o` is 0 and `cmpl_rdata_o` is 0.
- R6: An echo for a phase with nothing pending is ignored: `cmpl_o` stays 0 in the next cycle.
- R7: A request taken at edge t that gets no echo at edges t+1 through t+NUM_PHASES is re-sent at edge t+NUM_PHASES with the same tag and fields. This repeats every `NUM_PHASES` cycles until an echo arrives.
- R8: While phase `j` is pending, a new request from processor `j` is not taken. Its fields do not appear on the forward port, and any re-send carries the stored request.
- R9: An echo at edge t+NUM_PHASES counts as on time. No re-send happens, and a new request from the same processor can be taken at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Network cycle clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| phase_o | output | PH_W | Current phase slot |
| req_valid_i | input | NUM_PHASES | Request valid, one bit per processor |
| req_write_i | input | NUM_PHASES | 1 = write, 0 = read, one bit per processor |
| req_dest_i | input | NUM_PHASES*DEST_W | Destination memory cluster, per processor |
| req_addr_i | input | NUM_PHASES*ADDR_W | Word address, per processor |
| req_wdata_i | input | NUM_PHASES*DATA_W | Write data, per processor |
| req_ready_o | output | NUM_PHASES | Request is taken at the next edge if valid |
| fwd_valid_o | output | 1 | Forward network request valid |
| fwd_phase_o | output | PH_W | Source phase tag |
| fwd_write_o | output | 1 | Forward write flag |
| fwd_dest_o | output | DEST_W | Forward destination cluster |
| fwd_addr_o | output | ADDR_W | Forward address |
| fwd_wdata_o | output | DATA_W | Forward write data |
| bwd_valid_i | input | 1 | Backward echo valid |
| bwd_phase_i | input | PH_W | Echoed phase tag |
| bwd_rdata_i | input | DATA_W | Returned read data |
| cmpl_o | output | NUM_PHASES | One-hot completion pulse per processor |
| cmpl_rdata_o | output | DATA_W | Data that goes with the completion |

## Verification
`req_ready_o` is combinational and is due in the same cycle as the inputs that drive it. The bench checks it shortly after driving inputs in the low half of the clock. Forward requests and completion pulses are registered, so both are due one edge after the slot edge or echo edge. A reference model advances at each rising edge, queues the values expected after that edge, and a monitor compares them at the following falling edge. Re-sends are due exactly `NUM_PHASES` edges after the previous send. The bench counts sends per phase across several timeout windows, and places an echo exactly on the window boundary to cover R9.

// File: rtl/cluster_req_pkg.sv
package cluster_req_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE   = 2'd0,
    SLOT_NEW    = 2'd1,
    SLOT_RESEND = 2'd2
  } slot_act_e;
endpackage

// File: rtl/phase_ring.sv
module phase_ring #(
  parameter int NUM_PHASES = 4,
  localparam int PH_W = $clog2(NUM_PHASES)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  output logic [PH_W-1:0]       phase_o,
  output logic [NUM_PHASES-1:0] slot_o
);
  logic [PH_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (cnt_q == PH_W'(NUM_PHASES-1)) cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end

  for (genvar j = 0; j < NUM_PHASES; j++) begin : g_slot
    assign slot_o[j] = (cnt_q == PH_W'(j));
  end

  assign phase_o = cnt_q;
endmodule

// File: rtl/phase_slot.sv
module phase_slot
  import cluster_req_pkg::*;
#(
  parameter int NUM_PHASES = 4,
  parameter int DEST_W     = 4,
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 16,
  localparam int AGE_W     = $clog2(NUM_PHASES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_i,
  input  logic              echo_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [DEST_W-1:0] req_dest_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              ready_o,
  output logic              send_new_o,
  output logic              resend_o,
  output logic              hit_o,
  output logic              st_write_o,
  output logic [DEST_W-1:0] st_dest_o,
  output logic [ADDR_W-1:0] st_addr_o,
  output logic [DATA_W-1:0] st_wdata_o
);
  logic             pend_q;
  logic [AGE_W-1:0] age_q;
  logic             live, timeout, take;
  slot_act_e        act;

  assign hit_o   = echo_i & pend_q;
  assign live    = pend_q & ~hit_o;
  assign timeout = slot_i & live & (age_q == AGE_W'(NUM_PHASES));
  assign ready_o = slot_i & ~live;
  assign take    = ready_o & req_valid_i;

  always_comb begin
    if (take)         act = SLOT_NEW;
    else if (timeout) act = SLOT_RESEND;
    else              act = SLOT_IDLE;
  end

  assign send_new_o = (act == SLOT_NEW);
  assign resend_o   = (act == SLOT_RESEND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      age_q  <= '0;
    end else begin
      if (take)       pend_q <= 1'b1;
      else if (hit_o) pend_q <= 1'b0;
      // age counts edges since the last send, saturating at one window
      if (take || timeout)                            age_q <= AGE_W'(1);
      else if (pend_q && age_q != AGE_W'(NUM_PHASES)) age_q <= age_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_write_o <= 1'b0;
      st_dest_o  <= '0;
      st_addr_o  <= '0;
      st_wdata_o <= '0;
    end else if (take) begin
      st_write_o <= req_write_i;
      st_dest_o  <= req_dest_i;
      st_addr_o  <= req_addr_i;
      st_wdata_o <= req_wdata_i;
    end
  end
endmodule

// File: rtl/fwd_sel.sv
module fwd_sel #(
  parameter int NUM_PHASES = 4,
  parameter int DEST_W     = 4,
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 16,
  localparam int PH_W      = $clog2(NUM_PHASES)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_PHASES-1:0]        send_new_i,
  input  logic [NUM_PHASES-1:0]        resend_i,
  input  logic [NUM_PHASES-1:0]        in_write_i,
  input  logic [NUM_PHASES*DEST_W-1:0] in_dest_i,
  input  logic [NUM_PHASES*ADDR_W-1:0] in_addr_i,
  input  logic [NUM_PHASES*DATA_W-1:0] in_wdata_i,
  input  logic [NUM_PHASES-1:0]        st_write_i,
  input  logic [NUM_PHASES*DEST_W-1:0] st_dest_i,
  input  logic [NUM_PHASES*ADDR_W-1:0] st_addr_i,
  input  logic [NUM_PHASES*DATA_W-1:0] st_wdata_i,
  output logic                         fwd_valid_o,
  output logic [PH_W-1:0]              fwd_phase_o,
  output logic                         fwd_write_o,
  output logic [DEST_W-1:0]            fwd_dest_o,
  output logic [ADDR_W-1:0]            fwd_addr_o,
  output logic [DATA_W-1:0]            fwd_wdata_o
);
  logic              v_d, w_d;
  logic [PH_W-1:0]   ph_d;
  logic [DEST_W-1:0] dst_d;
  logic [ADDR_W-1:0] adr_d;
  logic [DATA_W-1:0] dat_d;

  // at most one slot is active per cycle
  always_comb begin
    v_d = 1'b0; w_d = 1'b0; ph_d = '0; dst_d = '0; adr_d = '0; dat_d = '0;
    for (int j = 0; j < NUM_PHASES; j++) begin
      if (send_new_i[j]) begin
        v_d   = 1'b1;
        ph_d  = PH_W'(j);
        w_d   = in_write_i[j];
        dst_d = in_dest_i[j*DEST_W +: DEST_W];
        adr_d = in_addr_i[j*ADDR_W +: ADDR_W];
        dat_d = in_wdata_i[j*DATA_W +: DATA_W];
      end else if (resend_i[j]) begin
        v_d   = 1'b1;
        ph_d  = PH_W'(j);
        w_d   = st_write_i[j];
        dst_d = st_dest_i[j*DEST_W +: DEST_W];
        adr_d = st_addr_i[j*ADDR_W +: ADDR_W];
        dat_d = st_wdata_i[j*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_valid_o <= 1'b0;
      fwd_phase_o <= '0;
      fwd_write_o <= 1'b0;
      fwd_dest_o  <= '0;
      fwd_addr_o  <= '0;
      fwd_wdata_o <= '0;
    end else begin
      fwd_valid_o <= v_d;
      fwd_phase_o <= ph_d;
      fwd_write_o <= w_d;
      fwd_dest_o  <= dst_d;
      fwd_addr_o  <= adr_d;
      fwd_wdata_o <= dat_d;
    end
  end
endmodule

// File: rtl/rsp_steer.sv
module rsp_steer #(
  parameter int NUM_PHASES = 4,
  parameter int DATA_W     = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PHASES-1:0] hit_i,
  input  logic [DATA_W-1:0]     rdata_i,
  output logic [NUM_PHASES-1:0] cmpl_o,
  output logic [DATA_W-1:0]     cmpl_rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmpl_o       <= '0;
      cmpl_rdata_o <= '0;
    end else begin
      cmpl_o       <= hit_i;
      cmpl_rdata_o <= (|hit_i) ? rdata_i : '0;
    end
  end
endmodule

// File: rtl/cluster_req_if.sv
module cluster_req_if #(
  parameter int NUM_PHASES = 4,
  parameter int DEST_W     = 4,
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 16,
  localparam int PH_W      = $clog2(NUM_PHASES)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  output logic [PH_W-1:0]              phase_o,
  input  logic [NUM_PHASES-1:0]        req_valid_i,
  input  logic [NUM_PHASES-1:0]        req_write_i,
  input  logic [NUM_PHASES*DEST_W-1:0] req_dest_i,
  input  logic [NUM_PHASES*ADDR_W-1:0] req_addr_i,
  input  logic [NUM_PHASES*DATA_W-1:0] req_wdata_i,
  output logic [NUM_PHASES-1:0]        req_ready_o,
  output logic                         fwd_valid_o,
  output logic [PH_W-1:0]              fwd_phase_o,
  output logic                         fwd_write_o,
  output logic [DEST_W-1:0]            fwd_dest_o,
  output logic [ADDR_W-1:0]            fwd_addr_o,
  output logic [DATA_W-1:0]            fwd_wdata_o,
  input  logic                         bwd_valid_i,
  input  logic [PH_W-1:0]              bwd_phase_i,
  input  logic [DATA_W-1:0]            bwd_rdata_i,
  output logic [NUM_PHASES-1:0]        cmpl_o,
  output logic [DATA_W-1:0]            cmpl_rdata_o
);
  logic [NUM_PHASES-1:0]        slot, send_new, resend, hit, st_write;
  logic [NUM_PHASES*DEST_W-1:0] st_dest;
  logic [NUM_PHASES*ADDR_W-1:0] st_addr;
  logic [NUM_PHASES*DATA_W-1:0] st_wdata;

  phase_ring #(.NUM_PHASES(NUM_PHASES)) u_ring (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_o (phase_o),
    .slot_o  (slot)
  );

  for (genvar j = 0; j < NUM_PHASES; j++) begin : g_ph
    phase_slot #(
      .NUM_PHASES(NUM_PHASES), .DEST_W(DEST_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .slot_i      (slot[j]),
      .echo_i      (bwd_valid_i && (bwd_phase_i == PH_W'(j))),
      .req_valid_i (req_valid_i[j]),
      .req_write_i (req_write_i[j]),
      .req_dest_i  (req_dest_i[j*DEST_W +: DEST_W]),
      .req_addr_i  (req_addr_i[j*ADDR_W +: ADDR_W]),
      .req_wdata_i (req_wdata_i[j*DATA_W +: DATA_W]),
      .ready_o     (req_ready_o[j]),
      .send_new_o  (send_new[j]),
      .resend_o    (resend[j]),
      .hit_o       (hit[j]),
      .st_write_o  (st_write[j]),
      .st_dest_o   (st_dest[j*DEST_W +: DEST_W]),
      .st_addr_o   (st_addr[j*ADDR_W +: ADDR_W]),
      .st_wdata_o  (st_wdata[j*DATA_W +: DATA_W])
    );
  end

  fwd_sel #(
    .NUM_PHASES(NUM_PHASES), .DEST_W(DEST_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_fwd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .send_new_i  (send_new),
    .resend_i    (resend),
    .in_write_i  (req_write_i),
    .in_dest_i   (req_dest_i),
    .in_addr_i   (req_addr_i),
    .in_wdata_i  (req_wdata_i),
    .st_write_i  (st_write),
    .st_dest_i   (st_dest),
    .st_addr_i   (st_addr),
    .st_wdata_i  (st_wdata),
    .fwd_valid_o (fwd_valid_o),
    .fwd_phase_o (fwd_phase_o),
    .fwd_write_o (fwd_write_o),
    .fwd_dest_o  (fwd_dest_o),
    .fwd_addr_o  (fwd_addr_o),
    .fwd_wdata_o (fwd_wdata_o)
  );

  rsp_steer #(.NUM_PHASES(NUM_PHASES), .DATA_W(DATA_W)) u_rsp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hit_i        (hit),
    .rdata_i      (bwd_rdata_i),
    .cmpl_o       (cmpl_o),
    .cmpl_rdata_o (cmpl_rdata_o)
  );
endmodule

// File: rtl/cluster_req_if_chk.sv
module cluster_req_if_chk #(
  parameter int NUM_PHASES = 4,
  parameter int DATA_W     = 16,
  localparam int PH_W      = $clog2(NUM_PHASES)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [PH_W-1:0]       phase_o,
  input logic [NUM_PHASES-1:0] req_ready_o,
  input logic                  fwd_valid_o,
  input logic [PH_W-1:0]       fwd_phase_o,
  input logic                  bwd_valid_i,
  input logic [PH_W-1:0]       bwd_phase_i,
  input logic [NUM_PHASES-1:0] cmpl_o
);
  logic warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warm_q <= 1'b0;
    else         warm_q <= 1'b1;
  end

  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm_q |-> phase_o == (($past(phase_o) == PH_W'(NUM_PHASES-1)) ? '0 : $past(phase_o) + 1'b1)); // R2

  AST_READY_OWN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o != '0) |-> (req_ready_o == (NUM_PHASES'(1) << phase_o))); // R3

  AST_FWD_TAG_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q && fwd_valid_o) |-> (fwd_phase_o == $past(phase_o))); // R4

  AST_CMPL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmpl_o)); // R5

  AST_CMPL_NEEDS_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q && cmpl_o != '0) |->
      ($past(bwd_valid_i) && cmpl_o == (NUM_PHASES'(1) << $past(bwd_phase_i)))); // R6
endmodule

bind cluster_req_if cluster_req_if_chk #(.NUM_PHASES(NUM_PHASES), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .phase_o     (phase_o),
  .req_ready_o (req_ready_o),
  .fwd_valid_o (fwd_valid_o),
  .fwd_phase_o (fwd_phase_o),
  .bwd_valid_i (bwd_valid_i),
  .bwd_phase_i (bwd_phase_i),
  .cmpl_o      (cmpl_o)
);

// File: tb/cluster_req_if_tb_top.sv
module cluster_req_if_tb_top;
  localparam int  NP = 4, DW = 4, AW = 12, XW = 16, PW = 2;
  localparam time CLK_PERIOD = 10ns;

  logic            clk = 1'b0, rst_n = 1'b0;
  logic [PW-1:0]   phase;
  logic [NP-1:0]   req_valid = '0, req_write = '0, req_ready;
  logic [NP*DW-1:0] req_dest = '0;
  logic [NP*AW-1:0] req_addr = '0;
  logic [NP*XW-1:0] req_wdata = '0;
  logic            fwd_valid, fwd_write;
  logic [PW-1:0]   fwd_phase;
  logic [DW-1:0]   fwd_dest;
  logic [AW-1:0]   fwd_addr;
  logic [XW-1:0]   fwd_wdata;
  logic            bwd_valid = 1'b0;
  logic [PW-1:0]   bwd_phase = '0;
  logic [XW-1:0]   bwd_rdata = '0;
  logic [NP-1:0]   cmpl;
  logic [XW-1:0]   cmpl_rdata;

  int n_checks = 0, n_fail = 0;
  int n_sent [NP];

  always #(CLK_PERIOD/2) clk = ~clk;

  cluster_req_if #(.NUM_PHASES(NP), .DEST_W(DW), .ADDR_W(AW), .DATA_W(XW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .phase_o(phase),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_dest_i(req_dest),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_ready_o(req_ready),
    .fwd_valid_o(fwd_valid), .fwd_phase_o(fwd_phase), .fwd_write_o(fwd_write),
    .fwd_dest_o(fwd_dest), .fwd_addr_o(fwd_addr), .fwd_wdata_o(fwd_wdata),
    .bwd_valid_i(bwd_valid), .bwd_phase_i(bwd_phase), .bwd_rdata_i(bwd_rdata),
    .cmpl_o(cmpl), .cmpl_rdata_o(cmpl_rdata)
  );

  typedef struct packed {
    logic [1:0]    kind;   // 0 idle, 1 new, 2 resend, 3 new after boundary echo
    logic [PW-1:0] ph_now;
    logic          fv;
    logic [PW-1:0] ph;
    logic          wr;
    logic [DW-1:0] dst;
    logic [AW-1:0] adr;
    logic [XW-1:0] dat;
    logic [NP-1:0] cm;
    logic [XW-1:0] rd;
  } exp_t;

  exp_t q[$];

  // reference state
  logic [PW-1:0] m_cnt = '0;
  logic [NP-1:0] m_pend = '0;
  logic          s_wr [NP];
  logic [DW-1:0] s_dst [NP];
  logic [AW-1:0] s_adr [NP];
  logic [XW-1:0] s_dat [NP];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // model: expected outputs after each edge, per the requirements
  always @(posedge clk) begin
    exp_t e;
    e = '0;
    if (!rst_n) begin
      m_cnt = '0; m_pend = '0;
    end else begin
      logic hit, live;
      int j;
      hit = bwd_valid && m_pend[bwd_phase];
      if (hit) begin e.cm[bwd_phase] = 1'b1; e.rd = bwd_rdata; end
      j = int'(m_cnt);
      live = m_pend[j] && !(hit && bwd_phase == m_cnt);
      if (hit) m_pend[bwd_phase] = 1'b0;
      if (live) begin
        e.kind = 2'd2; e.fv = 1'b1; e.ph = m_cnt;
        e.wr = s_wr[j]; e.dst = s_dst[j]; e.adr = s_adr[j]; e.dat = s_dat[j];
      end else if (req_valid[j]) begin
        e.kind = (hit && bwd_phase == m_cnt) ? 2'd3 : 2'd1;
        e.fv = 1'b1; e.ph = m_cnt;
        s_wr[j]  = req_write[j];
        s_dst[j] = req_dest[j*DW +: DW];
        s_adr[j] = req_addr[j*AW +: AW];
        s_dat[j] = req_wdata[j*XW +: XW];
        e.wr = s_wr[j]; e.dst = s_dst[j]; e.adr = s_adr[j]; e.dat = s_dat[j];
        m_pend[j] = 1'b1;
      end
      m_cnt = m_cnt + 1'b1;
    end
    e.ph_now = m_cnt;
    q.push_back(e);
  end

  // monitor
  always @(negedge clk) begin
    if (q.size() != 0) begin
      exp_t e;
      string tag;
      e = q.pop_front();
      case (e.kind)
        2'd2:    tag = "R7";
        2'd3:    tag = "R9";
        default: tag = "R4";
      endcase
      check(phase == e.ph_now, "R2", "phase_o", 64'(phase), 64'(e.ph_now));
      check(fwd_valid == e.fv, tag, "fwd_valid_o", 64'(fwd_valid), 64'(e.fv));
      if (e.fv) begin
        check(fwd_phase == e.ph && fwd_write == e.wr && fwd_dest == e.dst,
              tag, "fwd tag/write/dest", {fwd_phase, fwd_write, fwd_dest}, {e.ph, e.wr, e.dst});
        check(fwd_addr == e.adr && fwd_wdata == e.dat, tag, "fwd addr/data",
              {fwd_addr, fwd_wdata}, {e.adr, e.dat});
      end
      check(cmpl == e.cm && cmpl_rdata == e.rd, "R5", "cmpl/rdata",
            {cmpl, cmpl_rdata}, {e.cm, e.rd});
    end
    if (fwd_valid) n_sent[fwd_phase]++;
    #1;
    if (rst_n) begin
      logic [NP-1:0] er;
      er = '0;
      for (int j = 0; j < NP; j++)
        er[j] = (m_cnt == PW'(j)) && !(m_pend[j] && !(bwd_valid && bwd_phase == PW'(j)));
      check(req_ready == er, (m_pend[m_cnt] ? "R8" : "R3"), "req_ready_o",
            64'(req_ready), 64'(er));
    end
  end

  task automatic tick();
    @(negedge clk); #2;
  endtask

  task automatic wait_phase(input int p);
    while (phase != PW'(p)) tick();
  endtask

  task automatic set_req(input int p, input bit v, input bit w, input logic [DW-1:0] d,
                         input logic [AW-1:0] a, input logic [XW-1:0] x);
    req_valid[p] = v; req_write[p] = w;
    req_dest[p*DW +: DW] = d; req_addr[p*AW +: AW] = a; req_wdata[p*XW +: XW] = x;
  endtask

  task automatic echo(input bit v, input int p, input logic [XW-1:0] x);
    bwd_valid = v; bwd_phase = PW'(p); bwd_rdata = x;
  endtask

  initial begin
    for (int j = 0; j < NP; j++) n_sent[j] = 0;
    repeat (3) @(negedge clk);
    // R1: outputs held at rest during reset
    check(phase == '0 && !fwd_valid && cmpl == '0, "R1", "reset outputs",
          {phase, fwd_valid, cmpl}, 64'd0);
    @(negedge clk); rst_n = 1'b1; #2;

    // read from processor 0, echo two cycles later with data (R4, R5)
    wait_phase(0);
    set_req(0, 1, 0, 4'h3, 12'h012, 16'h0);
    tick(); set_req(0, 0, 0, 0, 0, 0);
    tick(); echo(1, 0, 16'hBEEF);
    tick(); echo(0, 0, 0);
    tick();

    // write from processor 1, never echoed: re-sends each window (R7)
    wait_phase(1);
    begin
      int base;
      base = n_sent[1];
      set_req(1, 1, 1, 4'h5, 12'h345, 16'hA5A5);
      tick(); set_req(1, 0, 0, 0, 0, 0);
      repeat (12) tick();
      check(n_sent[1] - base == 4, "R7", "sends of phase 1 over three windows",
            64'(n_sent[1] - base), 64'd4);
    end
    // R8: new request from busy processor 1 is refused
    wait_phase(1);
    set_req(1, 1, 0, 4'h9, 12'h999, 16'h9999);
    #1;
    check(req_ready[1] == 1'b0, "R8", "ready of pending phase", 64'(req_ready[1]), 64'd0);
    tick(); set_req(1, 0, 0, 0, 0, 0);
    check(fwd_valid && fwd_wdata == 16'hA5A5, "R8", "re-send keeps stored data",
          64'(fwd_wdata), 64'hA5A5);
    tick(); echo(1, 1, 16'h0001);
    tick(); echo(0, 0, 0);

    // R6: echo for a phase with nothing pending
    tick(); echo(1, 2, 16'h7777);
    tick(); echo(0, 0, 0);
    check(cmpl == '0, "R6", "cmpl after stray echo", 64'(cmpl), 64'd0);

    // R9: echo exactly at the window boundary, new request in the same slot
    wait_phase(3);
    set_req(3, 1, 0, 4'h1, 12'h0AB, 16'h1111);
    tick(); set_req(3, 0, 0, 0, 0, 0);
    wait_phase(3);
    echo(1, 3, 16'hC0DE);
    set_req(3, 1, 1, 4'h2, 12'h0CD, 16'h2222);
    tick(); echo(0, 0, 0); set_req(3, 0, 0, 0, 0, 0);
    check(fwd_valid && fwd_phase == 2'd3 && fwd_wdata == 16'h2222, "R9",
          "new request sent at boundary", {fwd_valid, fwd_phase, fwd_wdata},
          {1'b1, 2'd3, 16'h2222});
    check(cmpl == 4'b1000 && cmpl_rdata == 16'hC0DE, "R9", "boundary echo completes",
          {cmpl, cmpl_rdata}, {4'b1000, 16'hC0DE});
    repeat (5) tick();
    echo(1, 3, 16'h0); tick(); echo(0, 0, 0);

    // all phases back to back, each echoed two cycles after its send
    for (int c = 0; c < 20; c++) begin
      int p;
      p = int'(phase);
      set_req(p, 1, c[0], DW'(c), AW'(c * 7), XW'(c * 257));
      echo(1, int'(phase - PW'(2)), XW'(16'h4000 + c));
      tick();
      set_req(p, 0, 0, 0, 0, 0);
    end
    echo(0, 0, 0);
    repeat (8) tick();

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule